// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block arbitrates among 41 fixed interrupt sources for a CPU core. Each source has a pending flag that the source sets with a one-cycle raise strobe and that a clear strobe removes. Fifteen external lines and the non-maskable input have fixed levels. Every on-chip peripheral source takes a 4-bit level from one of three 16-bit priority registers. One nibble of a register can drive a whole group of sources.

The pending set is a bitmap. A balanced select tree finds the pending source with the highest level, and ties go to the lower source index. The winner's level is compared with the CPU's 4-bit mask and block bit to drive a registered request line. When the CPU pulses the accept strobe, the block latches the winner's fixed 12-bit exception code onto its code output. The source stays pending until it is cleared explicitly.

Top module: `vec_intc`

## Requirements
- R1: After a synchronous active-low reset, `irq_req` is 0, `int_code` is 0x000, the pending set is empty and all four registers read 0x0000.
- R2: Source index i maps to a fixed code. Indices 0..14 give 0x200+0x20·i. Index 15 gives 0x1C0. Indices 16 and 17 give 0x600 and 0x620. Indices 18..22 give 0x640+0x20·(i−18). Indices 23..40 give 0x400+0x20·(i−23) up to index 33 (0x540). Indices 34..37 give 0x700+0x20·(i−34). Indices 38..40 give 0x560, 0x580 and 0x5A0.
- R3: The timer register (offset 0x004) sets levels as follows. Nibble [15:12] sets index 23. Nibble [11:8] sets index 24. Nibble [7:4] sets indices 25 and 26. Nibble [3:0] sets indices 27..29.
- R4: The serial/watchdog register (offset 0x008) sets levels as follows. Nibble [15:12] sets index 38. Nibble [11:8] sets indices 39 and 40. Nibble [7:4] sets indices 30..33. Nibble [3:0] is stored but changes no level.
- R5: The DMA/port register (offset 0x00C) sets levels as follows. Nibble [15:12] sets index 17. Nibble [11:8] sets indices 18..22. Nibble [7:4] sets indices 34..37. Nibble [3:0] sets index 16.
- R6: Only address bits [11:0] are decoded. A read returns the last value written to that offset. The control register at offset 0x000 is stored but has no effect on arbitration.
- R7: External index i (0..14) has the fixed level 15−i. Index 15 has level 16, which exceeds every mask value. All other sources reset to level 0.
- R8: A raise of a source whose level is 0 leaves it not pending, even if its level is later made non-zero.
- R9: The highest pending level wins. On equal levels, the lower index wins.
- R10: `irq_req` is 1 only when some source is pending, `cpu_block` is 0 and `cpu_mask` is strictly less than the winner's level.
- R11: `int_accept` latches the winner's code onto `int_code` one cycle later without changing the pending set. `int_code` holds its value between accepts.
- R12: `irq_req` and the selected code follow a raise, clear, level or mask change two edges after the input is sampled. If a source is raised and cleared in the same cycle, the clear wins.
- R13: Raising an already pending source changes nothing, so a single clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 16 | Register address; bits [11:0] decoded |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| src_raise | input | 41 | Per-source raise strobes |
| src_clear | input | 41 | Per-source clear strobes |
| cpu_mask | input | 4 | CPU interrupt mask level |
| cpu_block | input | 1 | CPU block bit; 1 suppresses the request |
| int_accept | input | 1 | CPU accept strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| int_code | output | 12 | Exception code of the accepted source |

## Verification
The bench checks the tie-break on equal levels. A tree that favoured the right-hand child would report the timer capture code instead of the timer underflow code. It sets the mask equal to the winner's level: a `<=` compare would leave the request up. It also checks that the non-maskable source still requests under a mask of 15, which fails if levels are kept at 4 bits.

The bench raises a source while its level is 0 and then enables that level. A design that stored the raise would then assert a request. It writes the reserved nibble and the control register, writes through an aliased upper address, and drives a raise together with a clear on the same source. After each accept it checks that the source is still pending, which catches an accept that quietly removes the winner.

// File: rtl/intc_pkg.sv
// Package: shared constants, source indices, code map and arbitration
// candidate type for the vectored interrupt controller.
package intc_pkg;

    localparam int NUM_SRC  = 41;
    localparam int NUM_EXT  = 15;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int PRIO_W   = 5;
    localparam int CODE_W   = 12;
    localparam int REG_W    = 16;
    localparam int OFF_W    = 12;
    localparam int NIB_W    = 4;

    // Source indices (order sets the tie-break)
    localparam int SRC_NMI   = 15;
    localparam int SRC_DBG   = 16;
    localparam int SRC_PORT  = 17;
    localparam int SRC_DMA0  = 18;
    localparam int SRC_TMR0  = 23;
    localparam int SRC_RTC0  = 27;
    localparam int SRC_SER0  = 30;
    localparam int SRC_FIFO0 = 34;
    localparam int SRC_WDG   = 38;
    localparam int SRC_RFC0  = 39;

    localparam logic [PRIO_W-1:0] NMI_LVL = PRIO_W'(16);

    // Register offsets within the 12-bit decoded window
    localparam logic [OFF_W-1:0] OFF_CTRL = 12'h000;
    localparam logic [OFF_W-1:0] OFF_PRA  = 12'h004;
    localparam logic [OFF_W-1:0] OFF_PRB  = 12'h008;
    localparam logic [OFF_W-1:0] OFF_PRC  = 12'h00C;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] lvl;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    // Computes the fixed exception code of a source index.
    function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
        int i;
        int v;
        i = int'(idx);
        if (i < NUM_EXT)            v = 'h200 + 'h20 * i;
        else if (i == SRC_NMI)      v = 'h1C0;
        else if (i < SRC_DMA0)      v = 'h600 + 'h20 * (i - SRC_DBG);
        else if (i < SRC_TMR0)      v = 'h640 + 'h20 * (i - SRC_DMA0);
        else if (i < SRC_FIFO0)     v = 'h400 + 'h20 * (i - SRC_TMR0);
        else if (i < SRC_WDG)       v = 'h700 + 'h20 * (i - SRC_FIFO0);
        else                        v = 'h560 + 'h20 * (i - SRC_WDG);
        return CODE_W'(v);
    endfunction

endpackage

// File: rtl/intc_prio_regs.sv
// Module: priority register file. Holds the control and three priority
// registers, decodes the low address bits, and fans each nibble out to its
// source group. Assumes single-cycle write strobes; reads are combinational.
module intc_prio_regs
    import intc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    output logic [REG_W-1:0]                rdata,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o
);

    logic [OFF_W-1:0] off;
    logic [REG_W-1:0] ctrl_q, pra_q, prb_q, prc_q;
    logic             unused_hi;

    assign off       = addr[OFF_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:OFF_W];

    // Store writes to the four decoded offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pra_q  <= '0;
            prb_q  <= '0;
            prc_q  <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_CTRL: ctrl_q <= wdata;
                OFF_PRA:  pra_q  <= wdata;
                OFF_PRB:  prb_q  <= wdata;
                OFF_PRC:  prc_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Return the stored value of the addressed register.
    always_comb begin
        case (off)
            OFF_CTRL: rdata = ctrl_q;
            OFF_PRA:  rdata = pra_q;
            OFF_PRB:  rdata = prb_q;
            OFF_PRC:  rdata = prc_q;
            default:  rdata = '0;
        endcase
    end

    // Build per-source levels from fixed values and register nibbles.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) prio_o[i] = '0;
        for (int i = 0; i < NUM_EXT; i++) prio_o[i] = PRIO_W'(NUM_EXT - i);
        prio_o[SRC_NMI] = NMI_LVL;
        prio_o[SRC_TMR0]     = {1'b0, pra_q[15:12]};
        prio_o[SRC_TMR0 + 1] = {1'b0, pra_q[11:8]};
        for (int i = 2; i < 4; i++) prio_o[SRC_TMR0 + i] = {1'b0, pra_q[7:4]};
        for (int i = 0; i < 3; i++) prio_o[SRC_RTC0 + i] = {1'b0, pra_q[3:0]};
        prio_o[SRC_WDG] = {1'b0, prb_q[15:12]};
        for (int i = 0; i < 2; i++) prio_o[SRC_RFC0 + i] = {1'b0, prb_q[11:8]};
        for (int i = 0; i < 4; i++) prio_o[SRC_SER0 + i] = {1'b0, prb_q[7:4]};
        prio_o[SRC_PORT] = {1'b0, prc_q[15:12]};
        for (int i = 0; i < 5; i++) prio_o[SRC_DMA0 + i]  = {1'b0, prc_q[11:8]};
        for (int i = 0; i < 4; i++) prio_o[SRC_FIFO0 + i] = {1'b0, prc_q[7:4]};
        prio_o[SRC_DBG] = {1'b0, prc_q[3:0]};
    end

endmodule

// File: rtl/intc_pending.sv
// Module: pending bitmap. Sets a flag on a raise when the source's level is
// non-zero, clears it on a clear strobe (clear wins). Assumes strobes are
// one cycle wide; repeated raises are idempotent.
module intc_pending
    import intc_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              raise_i,
    input  logic [NUM_SRC-1:0]              clear_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
    output logic [NUM_SRC-1:0]              pend_o
);

    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] pend_q;

    // Flag sources that currently have a non-zero level.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) en[i] = |prio_i[i];
    end

    // Update the bitmap: enabled raises set, clears reset with precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | (raise_i & en)) & ~clear_i;
    end

    assign pend_o = pend_q;

    assert_masked_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raise_i & ~en & ~pend_q)) |=> ((pend_q & $past(raise_i & ~en & ~pend_q)) == '0));

    assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_i) |=> ((pend_q & $past(clear_i)) == '0));

    assert_no_silent_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & ~clear_i)) |=>
            ((pend_q & $past(pend_q & ~clear_i)) == $past(pend_q & ~clear_i)));

endmodule

// File: rtl/intc_arbiter.sv
// Module: combinational priority-select tree over the pending bitmap.
// Leaves are padded to a power of two; the left child (lower indices) wins
// ties, giving a fixed lowest-index tie-break.
module intc_arbiter
    import intc_pkg::*;
(
    input  logic [NUM_SRC-1:0]              pend_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
    output logic                            win_vld,
    output logic [PRIO_W-1:0]               win_lvl,
    output logic [IDX_W-1:0]                win_idx
);

    localparam int LEAVES = 1 << $clog2(NUM_SRC);
    localparam int NODES  = 2 * LEAVES - 1;

    cand_t node [NODES];

    // Choose between two candidates; the left one keeps ties.
    function automatic cand_t pick(input cand_t l, input cand_t r);
        if (r.vld && (!l.vld || (r.lvl > l.lvl))) return r;
        return l;
    endfunction

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            assign node[LEAVES - 1 + i] = '{vld: pend_i[i], lvl: prio_i[i], idx: IDX_W'(i)};
        end else begin : g_pad
            assign node[LEAVES - 1 + i] = '{vld: 1'b0, lvl: '0, idx: '0};
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        assign node[k] = pick(node[2*k + 1], node[2*k + 2]);
    end

    assign win_vld = node[0].vld;
    assign win_lvl = node[0].lvl;
    assign win_idx = node[0].idx;

endmodule

// File: rtl/vec_intc.sv
// Module: top of the vectored interrupt controller. Registers the request
// and the selected code one cycle after arbitration, and latches the code
// on the CPU accept strobe. Assumes mask and block come from the CPU status.
module vec_intc
    import intc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                reg_we,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_SRC-1:0]  src_raise,
    input  logic [NUM_SRC-1:0]  src_clear,
    input  logic [NIB_W-1:0]    cpu_mask,
    input  logic                cpu_block,
    input  logic                int_accept,
    output logic                irq_req,
    output logic [CODE_W-1:0]   int_code
);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [NUM_SRC-1:0]             pending;
    logic                           win_vld;
    logic [PRIO_W-1:0]              win_lvl;
    logic [IDX_W-1:0]               win_idx;
    logic                           req_q;
    logic [CODE_W-1:0]              sel_code_q, code_q;

    intc_prio_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .prio_o(prio)
    );

    intc_pending pend_i (
        .clk(clk), .rst_n(rst_n), .raise_i(src_raise), .clear_i(src_clear),
        .prio_i(prio), .pend_o(pending)
    );

    intc_arbiter arb_i (
        .pend_i(pending), .prio_i(prio),
        .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
    );

    // Register the request decision and the winner's code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            sel_code_q <= '0;
        end else begin
            req_q      <= win_vld && !cpu_block && ({1'b0, cpu_mask} < win_lvl);
            sel_code_q <= win_vld ? src_code(win_idx) : '0;
        end
    end

    // Latch the selected code when the CPU accepts.
    always_ff @(posedge clk) begin
        if (!rst_n)          code_q <= '0;
        else if (int_accept) code_q <= sel_code_q;
    end

    assign irq_req  = req_q;
    assign int_code = code_q;

    assert_block_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_block |=> !irq_req);

    assert_empty_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |=> !irq_req);

    assert_top_mask_nmi_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mask == 4'hF && !pending[SRC_NMI]) |=> !irq_req);

    assert_code_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !int_accept |=> $stable(int_code));

endmodule

// File: tb/vec_intc_tb.sv
`timescale 1ns/1ps
module vec_intc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic [40:0] src_raise = '0;
    logic [40:0] src_clear = '0;
    logic [3:0]  cpu_mask = '0;
    logic        cpu_block = 1'b0;
    logic        int_accept = 1'b0;
    logic        irq_req;
    logic [11:0] int_code;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int          q_cyc[$];
    bit          q_chk_code[$];
    bit          q_req[$];
    logic [11:0] q_code[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    vec_intc dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .src_raise(src_raise),
        .src_clear(src_clear), .cpu_mask(cpu_mask), .cpu_block(cpu_block),
        .int_accept(int_accept), .irq_req(irq_req), .int_code(int_code)
    );

    function automatic logic [40:0] bit1(input int i);
        return 41'(1) << i;
    endfunction

    // Monitor: pop expected items due this cycle and compare.
    always @(posedge clk) begin
        #1;
        cyc++;
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            n_chk++;
            if (irq_req !== q_req[0] || (q_chk_code[0] && int_code !== q_code[0])) begin
                n_fail++;
                $display("FAIL %s: req=%0b code=%03h expected req=%0b code=%03h",
                         q_tag[0], irq_req, int_code, q_req[0], q_code[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_chk_code.pop_front());
            void'(q_req.pop_front());
            void'(q_code.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic push(input int at, input bit cc, input bit r, input logic [11:0] c, input string tag);
        q_cyc.push_back(at); q_chk_code.push_back(cc); q_req.push_back(r);
        q_code.push_back(c); q_tag.push_back(tag);
    endtask

    task automatic pulse(input logic [40:0] r, input logic [40:0] c);
        src_raise = r; src_clear = c;
        @(negedge clk);
        src_raise = '0; src_clear = '0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        pulse('0, '1);
    endtask

    task automatic set_cpu(input logic [3:0] m, input bit b);
        cpu_mask = m; cpu_block = b;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic probe(input bit r, input logic [11:0] c, input string tag);
        int_accept = 1'b1;
        push(cyc + 1, 1'b1, r, c, tag);
        @(negedge clk);
        int_accept = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_req(input bit r, input string tag);
        push(cyc + 1, 1'b0, r, '0, tag);
        @(negedge clk); @(negedge clk);
    endtask

    task automatic chk_rd(input logic [15:0] a, input logic [15:0] e, input string tag);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: rdata=%04h expected %04h", tag, reg_rdata, e);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++; n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_chk++;
        if (irq_req !== 1'b0 || int_code !== 12'h000) begin
            n_fail++;
            $display("FAIL R1: req=%0b code=%03h expected 0/000", irq_req, int_code);
        end
        chk_rd(16'h0004, 16'h0000, "R1 reset register");

        // R12 timing, R2/R11 code and hold
        src_raise = bit1(3);
        push(cyc + 1, 1'b0, 1'b0, '0, "R12 no request one edge after raise");
        push(cyc + 2, 1'b0, 1'b1, '0, "R12 request two edges after raise");
        @(negedge clk); src_raise = '0; @(negedge clk);
        probe(1'b1, 12'h260, "R2 ext 3 code");
        probe(1'b1, 12'h260, "R11 accept keeps source pending");

        // R9 higher level wins, clear reveals previous
        pulse(bit1(1), '0);
        probe(1'b1, 12'h220, "R9 ext 1 beats ext 3");
        pulse('0, bit1(1));
        probe(1'b1, 12'h260, "R11 clear removes only ext 1");

        // R10 mask strict and block
        set_cpu(4'd12, 1'b0); chk_req(1'b0, "R10 mask equal to level");
        set_cpu(4'd11, 1'b0); chk_req(1'b1, "R10 mask below level");
        set_cpu(4'd0, 1'b1);  chk_req(1'b0, "R10 block bit");
        set_cpu(4'd0, 1'b0);
        clear_all();
        chk_req(1'b0, "R10 empty set");

        // R8 masked raise then R3 timer nibble
        pulse(bit1(23), '0);
        chk_req(1'b0, "R8 raise at level 0");
        wr(16'h0004, 16'h5000);
        chk_req(1'b0, "R8 masked raise not stored");
        pulse(bit1(23), '0);
        probe(1'b1, 12'h400, "R3 timer 0 code");
        clear_all();

        // R3 shared nibble and tie-break
        wr(16'h0004, 16'h0070);
        set_cpu(4'd6, 1'b0);
        pulse(bit1(26), '0);
        probe(1'b1, 12'h460, "R3 capture via nibble 7:4");
        pulse(bit1(25), '0);
        probe(1'b1, 12'h440, "R9 tie goes to lower index");
        set_cpu(4'd7, 1'b0); chk_req(1'b0, "R10 mask equals shared level");
        set_cpu(4'd0, 1'b0);
        clear_all();
        wr(16'h0004, 16'h0003);
        pulse(bit1(29), '0);
        probe(1'b1, 12'h4C0, "R3 rtc via nibble 3:0");
        clear_all();

        // R4 reserved nibble and groups
        wr(16'h0008, 16'h000F);
        pulse(bit1(38), '0);
        chk_req(1'b0, "R4 reserved nibble leaves watchdog at 0");
        wr(16'h0008, 16'h3000);
        pulse(bit1(38), '0);
        probe(1'b1, 12'h560, "R4 watchdog code");
        clear_all();
        wr(16'h0008, 16'h0A00);
        pulse(bit1(40), '0);
        probe(1'b1, 12'h5A0, "R4 refresh overflow code");
        pulse(bit1(39), '0);
        probe(1'b1, 12'h580, "R9 refresh tie lower index");
        clear_all();
        wr(16'h0008, 16'h00B0);
        pulse(bit1(30) | bit1(33), '0);
        probe(1'b1, 12'h4E0, "R4 serial group");
        clear_all();

        // R5 port/dma/fifo/debug ordering
        wr(16'h000C, 16'h8241);
        pulse(bit1(16) | bit1(22) | bit1(37) | bit1(17), '0);
        probe(1'b1, 12'h620, "R5 port level 8 wins");
        pulse('0, bit1(17));
        probe(1'b1, 12'h760, "R5 fifo level 4");
        pulse('0, bit1(37));
        probe(1'b1, 12'h6C0, "R5 dma error level 2");
        pulse('0, bit1(22));
        probe(1'b1, 12'h600, "R5 debug level 1");
        chk_rd(16'h000C, 16'h8241, "R6 readback");
        clear_all();

        // R6 aliasing and control register
        wr(16'hF004, 16'h1234);
        chk_rd(16'h0004, 16'h1234, "R6 upper address bits ignored");
        wr(16'h0000, 16'hFFFF);
        chk_rd(16'h0000, 16'hFFFF, "R6 control readback");
        pulse(bit1(14), '0);
        probe(1'b1, 12'h3C0, "R6 control has no effect, R7 ext 14 level 1");
        clear_all();

        // R7 non-maskable level
        set_cpu(4'd15, 1'b0);
        pulse(bit1(15), '0);
        probe(1'b1, 12'h1C0, "R7 level 16 over mask 15");
        pulse(bit1(0), '0);
        probe(1'b1, 12'h1C0, "R7 level 16 beats ext 0");
        pulse('0, bit1(15));
        chk_req(1'b0, "R7 ext 0 level 15 under mask 15");
        set_cpu(4'd14, 1'b0);
        probe(1'b1, 12'h200, "R7 ext 0 level 15");
        set_cpu(4'd0, 1'b0);
        clear_all();

        // R12 clear beats raise
        pulse(bit1(5), bit1(5));
        chk_req(1'b0, "R12 clear and raise same cycle");

        // R13 double raise
        pulse(bit1(2), '0);
        pulse(bit1(2), '0);
        probe(1'b1, 12'h240, "R13 ext 2 pending");
        pulse('0, bit1(2));
        chk_req(1'b0, "R13 single clear removes it");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule